// File: doc/BRIEF.md
# Threshold Sweep Controller with Best-Split Hold

This block drives the search for the best single-dimension decision threshold of a learning classifier. After a start pulse it sets a candidate threshold to a configured first value, raises a request so that an external source replays the whole training set to an evaluation unit, and waits for that unit to return one quality index for the candidate. It then compares the returned index with the best index kept so far and keeps the better one together with the threshold that produced it.

The candidate then moves up by a fixed step, and the block asks for a fresh full replay. This repeats until no further step fits under the configured maximum. At that point a done flag rises and stays high. A one-cycle output-enable pulse marks the moment the winning threshold may be read. The entropy arithmetic is outside this block. It only sees a valid strobe and an unsigned index in which a larger value is better.

Top module: `thr_sweep_top`

## Requirements
- R1: After reset the block is idle: `request`, `done` and `oe` are 0, `curThr` and `bestThr` equal THR_INIT (default 0), and `bestIdx` is 0.
- R2: A `start` sampled while idle or done reloads `curThr` and `bestThr` with THR_INIT and `bestIdx` with 0, its worst value. It also clears `done`, and `request` is 1 in the next cycle.
- R3: `request` is 1 from the cycle after a sweep begins or the threshold steps, up to and including the cycle in which `resultValid` is sampled. It is 0 in the compare and step cycles that follow, so it falls before every new threshold.
- R4: `resultValid` is ignored unless the block is waiting for a result. A stray pulse while done leaves `bestIdx` and `bestThr` unchanged.
- R5: A returned index replaces `bestIdx`, and `curThr` replaces `bestThr`, only when the index is strictly greater than `bestIdx`. On a tie the lower threshold is kept.
- R6: Candidates are THR_INIT, THR_INIT+THR_STEP, and so on. The threshold rises by exactly THR_STEP in the cycle after a compare that is not the last.
- R7: The candidate is the last one when adding THR_STEP would exceed THR_MAX. Two cycles after its result is sampled, `done` goes to 1 and stays 1 until the next `start`. `bestThr` then holds the winning threshold.
- R8: `oe` is 1 for exactly the first cycle of `done` and is 0 at every other time.
- R9: A `start` while a sweep is running has no effect on the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new sweep (honoured only when idle or done) |
| resultValid | input | 1 | Evaluator has a quality index for the current threshold |
| resultIdx | input | IDX_W | Quality index, unsigned, larger is better |
| request | output | 1 | Ask the source to replay the training set |
| done | output | 1 | Sweep complete, held until next start |
| oe | output | 1 | One-cycle read strobe for the winning threshold |
| curThr | output | DATA_W | Threshold currently being evaluated |
| bestThr | output | DATA_W | Threshold that gave the best index so far |
| bestIdx | output | IDX_W | Best index so far |

## Verification
The update of the best pair and the end of the sweep can come out of the same compare cycle: the last candidate's index wins and `done` rises one cycle later. This is provoked with a score profile that rises with the threshold, so the winner is the final candidate, and it is judged by the final `bestThr` and by the cycle in which `done` and `oe` rise. A profile with equal scores and one with a repeated peak show that ties keep the earlier threshold. A start pulse during a sweep and a stray result pulse after done show that inputs outside their state are ignored. A behavioural model compares every output in every cycle.

// File: rtl/thr_sweep_pkg.sv
package thr_sweep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQUEST = 3'd1,
    ST_WAIT    = 3'd2,
    ST_COMPARE = 3'd3,
    ST_STEP    = 3'd4,
    ST_DONE    = 3'd5
  } sweep_state_t;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic initAll;
    logic latchResult;
    logic doCompare;
    logic stepThr;
  } sweep_strobe_t;

endpackage

// File: rtl/thr_sweep_ctrl.sv
module thr_sweep_ctrl
  import thr_sweep_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          resultValid,
  input  logic          lastThr,
  output sweep_strobe_t strobe,
  output logic          request,
  output logic          done,
  output logic          oe
);

  sweep_state_t stCur, stNext;
  logic oeQ;

  always_comb begin
    stNext = stCur;
    strobe = '0;
    unique case (stCur)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          strobe.initAll = 1'b1;
          stNext = ST_REQUEST;
        end
      end
      ST_REQUEST: stNext = ST_WAIT;
      ST_WAIT: begin
        if (resultValid) begin
          strobe.latchResult = 1'b1;
          stNext = ST_COMPARE;
        end
      end
      ST_COMPARE: begin
        strobe.doCompare = 1'b1;
        stNext = lastThr ? ST_DONE : ST_STEP;
      end
      ST_STEP: begin
        strobe.stepThr = 1'b1;
        stNext = ST_REQUEST;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stCur <= ST_IDLE;
      oeQ   <= 1'b0;
    end else begin
      stCur <= stNext;
      oeQ   <= (stNext == ST_DONE) && (stCur != ST_DONE);
    end
  end

  assign request = (stCur == ST_REQUEST) || (stCur == ST_WAIT);
  assign done    = (stCur == ST_DONE);
  assign oe      = oeQ;

  // R7: done holds until a start is seen
  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  // R8: output enable is a single-cycle pulse inside done
  assert_oe_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    oe |=> !oe);
  assert_oe_in_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    oe |-> done);

  // R3: request drops before the threshold advances
  assert_req_low_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepThr |-> !request);

  // R9: a start seen while waiting does not leave the wait
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stCur == ST_WAIT && !resultValid) |=> request);

endmodule

// File: rtl/thr_sweep_datapath.sv
module thr_sweep_datapath
  import thr_sweep_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 8,
  parameter int THR_INIT = 0,
  parameter int THR_STEP = 16,
  parameter int THR_MAX  = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  sweep_strobe_t     strobe,
  input  logic [IDX_W-1:0]  resultIdx,
  output logic [DATA_W-1:0] curThr,
  output logic [DATA_W-1:0] bestThr,
  output logic [IDX_W-1:0]  bestIdx,
  output logic              lastThr
);

  localparam int SUM_W = DATA_W + 1;
  localparam logic [DATA_W-1:0] INIT_V = DATA_W'(THR_INIT);
  localparam logic [DATA_W-1:0] STEP_V = DATA_W'(THR_STEP);
  localparam logic [SUM_W-1:0]  STEP_W = SUM_W'(THR_STEP);
  localparam logic [SUM_W-1:0]  MAX_W  = SUM_W'(THR_MAX);

  logic [IDX_W-1:0] heldIdx;
  logic [SUM_W-1:0] nextThrWide;
  logic             improves;

  assign nextThrWide = {1'b0, curThr} + STEP_W;
  assign lastThr     = nextThrWide > MAX_W;
  assign improves    = heldIdx > bestIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curThr  <= INIT_V;
      bestThr <= INIT_V;
      bestIdx <= '0;
      heldIdx <= '0;
    end else begin
      if (strobe.initAll) begin
        curThr  <= INIT_V;
        bestThr <= INIT_V;
        bestIdx <= '0;
      end
      if (strobe.latchResult) heldIdx <= resultIdx;
      if (strobe.doCompare && improves) begin
        bestIdx <= heldIdx;
        bestThr <= curThr;
      end
      if (strobe.stepThr) curThr <= curThr + STEP_V;
    end
  end

  // R5: the best index never decreases within a sweep
  assert_best_monotonic_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.initAll |=> bestIdx >= $past(bestIdx));

  // R6: each step adds exactly the configured increment
  assert_step_size_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepThr |=> curThr == $past(curThr) + STEP_V);

  // R4: best pair only moves on a compare or a restart
  assert_best_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.doCompare && !strobe.initAll) |=> $stable(bestThr));

endmodule

// File: rtl/thr_sweep_top.sv
module thr_sweep_top
  import thr_sweep_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 8,
  parameter int THR_INIT = 0,
  parameter int THR_STEP = 16,
  parameter int THR_MAX  = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              resultValid,
  input  logic [IDX_W-1:0]  resultIdx,
  output logic              request,
  output logic              done,
  output logic              oe,
  output logic [DATA_W-1:0] curThr,
  output logic [DATA_W-1:0] bestThr,
  output logic [IDX_W-1:0]  bestIdx
);

  sweep_strobe_t strobe;
  logic          lastThr;

  thr_sweep_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .resultValid (resultValid),
    .lastThr     (lastThr),
    .strobe      (strobe),
    .request     (request),
    .done        (done),
    .oe          (oe)
  );

  thr_sweep_datapath #(
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W),
    .THR_INIT (THR_INIT),
    .THR_STEP (THR_STEP),
    .THR_MAX  (THR_MAX)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .resultIdx (resultIdx),
    .curThr    (curThr),
    .bestThr   (bestThr),
    .bestIdx   (bestIdx),
    .lastThr   (lastThr)
  );

  // R1: reset leaves every handshake output low
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!request && !done && !oe));

endmodule

// File: tb/thr_sweep_top_bench.sv
module thr_sweep_top_bench;

  localparam int DATA_W   = 8;
  localparam int IDX_W    = 8;
  localparam int THR_INIT = 0;
  localparam int THR_STEP = 16;
  localparam int THR_MAX  = 200;
  localparam int LAT      = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic evalValid = 1'b0;
  logic strayValid = 1'b0;
  logic [IDX_W-1:0] evalIdx = '0;
  logic resultValid;
  logic [IDX_W-1:0] resultIdx;
  logic request, done, oe;
  logic [DATA_W-1:0] curThr, bestThr;
  logic [IDX_W-1:0] bestIdx;

  assign resultValid = evalValid | strayValid;
  assign resultIdx   = strayValid ? 8'hFF : evalIdx;

  always #5 clk = ~clk;

  thr_sweep_top #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .THR_INIT(THR_INIT),
    .THR_STEP(THR_STEP), .THR_MAX(THR_MAX)
  ) u_thr_sweep_top (
    .clk(clk), .rstN(rstN), .start(start), .resultValid(resultValid),
    .resultIdx(resultIdx), .request(request), .done(done), .oe(oe),
    .curThr(curThr), .bestThr(bestThr), .bestIdx(bestIdx)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int mode = 0;

  function automatic int score(int m, int t);
    int d;
    case (m)
      0: begin d = (t > 100) ? t - 100 : 100 - t; score = 250 - 2 * d; if (score < 0) score = 0; end
      1: score = 77;
      2: score = t / 2 + 1;
      3: score = 0;
      default: score = (t == 48 || t == 144) ? 180 : 10;
    endcase
  endfunction

  function automatic int expectBestThr(int m);
    int b = 0;
    expectBestThr = THR_INIT;
    for (int t = THR_INIT; t <= THR_MAX; t += THR_STEP)
      if (score(m, t) > b) begin b = score(m, t); expectBestThr = t; end
  endfunction

  function automatic int expectBestIdx(int m);
    expectBestIdx = 0;
    for (int t = THR_INIT; t <= THR_MAX; t += THR_STEP)
      if (score(m, t) > expectBestIdx) expectBestIdx = score(m, t);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Evaluator emulation: answers each request after LAT cycles.
  bit pending = 0;
  int waitCnt = 0;
  always @(posedge clk) begin
    #1;
    evalValid = 1'b0;
    if (pending) begin
      waitCnt--;
      if (waitCnt == 0) begin
        evalValid = 1'b1;
        evalIdx = IDX_W'(score(mode, int'(curThr)));
        pending = 0;
      end
    end else if (request && rstN) begin
      pending = 1;
      waitCnt = LAT;
    end
  end

  // Behavioural reference: 0 idle, 1 ask, 2 wait, 3 judge, 4 advance, 5 finished
  int mSt = 0, mCur = THR_INIT, mBest = 0, mBestThr = THR_INIT, mHeld = 0;
  bit mOe = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mCur = THR_INIT; mBest = 0; mBestThr = THR_INIT; mOe = 0;
    end else begin
      mOe = 0;
      case (mSt)
        0, 5: if (start) begin mSt = 1; mCur = THR_INIT; mBest = 0; mBestThr = THR_INIT; end
        1: mSt = 2;
        2: if (resultValid) begin mHeld = int'(resultIdx); mSt = 3; end
        3: begin
          if (mHeld > mBest) begin mBest = mHeld; mBestThr = mCur; end
          if (mCur + THR_STEP > THR_MAX) begin mSt = 5; mOe = 1; end
          else mSt = 4;
        end
        default: begin mCur += THR_STEP; mSt = 1; end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check("R3", "request", int'(request), int'(mSt == 1 || mSt == 2));
      check("R7", "done", int'(done), int'(mSt == 5));
      check("R8", "oe", int'(oe), int'(mOe));
      check("R6", "curThr", int'(curThr), mCur);
      check("R5", "bestIdx", int'(bestIdx), mBest);
      check("R5", "bestThr", int'(bestThr), mBestThr);
    end
  end

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  task automatic pulseStart();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic runSweep(int m);
    mode = m;
    pulseStart();
    @(negedge clk);
    check("R2", "request after start", int'(request), 1);
    check("R2", "curThr after start", int'(curThr), THR_INIT);
    check("R2", "bestIdx after start", int'(bestIdx), 0);
    while (!done) @(negedge clk);
    check("R8", "oe on first done cycle", int'(oe), 1);
    check("R7", "final bestThr", int'(bestThr), expectBestThr(m));
    check("R5", "final bestIdx", int'(bestIdx), expectBestIdx(m));
    repeat (3) @(negedge clk);
    check("R7", "done held", int'(done), 1);
    check("R8", "oe after first cycle", int'(oe), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "request", int'(request), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "oe", int'(oe), 0);
    check("R1", "curThr", int'(curThr), THR_INIT);
    check("R1", "bestThr", int'(bestThr), THR_INIT);
    check("R1", "bestIdx", int'(bestIdx), 0);
    @(posedge clk); #1 rstN = 1'b1;

    runSweep(0);

    // R4: stray result while done must not disturb the stored best pair
    @(posedge clk); #1 strayValid = 1'b1;
    @(posedge clk); #1 strayValid = 1'b0;
    @(negedge clk);
    check("R4", "bestIdx after stray result", int'(bestIdx), expectBestIdx(0));
    check("R4", "bestThr after stray result", int'(bestThr), expectBestThr(0));

    runSweep(1);
    runSweep(2);
    runSweep(3);
    runSweep(4);

    // R9: start in the middle of a sweep is ignored
    mode = 0;
    pulseStart();
    while (curThr != 8'd64) @(negedge clk);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    check("R9", "curThr kept after mid-sweep start", int'(curThr >= 8'd64), 1);
    check("R9", "done low mid-sweep", int'(done), 0);
    while (!done) @(negedge clk);
    check("R9", "sweep finished normally", int'(bestThr), expectBestThr(0));

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule